// File: doc/BRIEF.md
# Sensorless Spindle Commutation Clock Generator

This block times the commutation of a sensorless three-phase spindle motor. It takes the zero-crossing feedback pulse train (FG), which toggles once per back-EMF zero crossing. It removes short noise from FG and measures the time between accepted FG edges in units of a synchronous tick. From that measurement it produces a single-tick commutation clock (MCLK) and a blanking window (MASK). MASK opens with every MCLK pulse and hides the commutation spike from the edge detector.

The controller selects one of three phases of spin-up with a two-bit mode input. In start-up the clock runs at a fixed period and no interval is used. In acceleration the clock fires half an interval after each FG edge. In running it fires one thirty-second of an interval after the edge. During start-up each FG edge is checked against the polarity that the commutation sequence expects. A wrong polarity raises a retry pulse and restarts the start-up sequence. If the interval counter saturates because the motor is too slow or has stopped, the block falls back to start-up timing. It stays there until it measures an interval that has not saturated.

Top module: `bldc_comm_clock`

## Requirements
- R1: While rst_n is low, mclk, mask and retry are all 0.
- R2: A new FG level is accepted only after it has been present on QUAL_TICKS consecutive ticks. A pulse lasting fewer ticks produces no edge.
- R3: With mode 2'b00 (start-up), mclk pulses every START_PERIOD ticks. Each pulse opens a mask lasting START_MASK ticks.
- R4: With mode 2'b01 (acceleration), mclk fires (N>>1) ticks after an accepted FG edge, where N is the interval that edge closed. The mask that follows lasts (N>>2) ticks.
- R5: With mode 2'b10 or 2'b11 (running), mclk fires (N>>5) ticks after an accepted FG edge. The mask that follows lasts RUN_MASK ticks.
- R6: While mask is high, FG transitions are ignored. A pulse that lies wholly inside the mask causes no edge and no retry.
- R7: In start-up the expected polarity starts at 0 and flips on each start-up mclk. An accepted edge whose new FG level differs from it raises retry for one clock. It also restarts the start-up period, so the next mclk comes START_PERIOD ticks after the retry. An edge that matches raises no retry.
- R8: When the interval counter reaches its maximum, start-up timing (R3) is used whatever the mode. Reset also leaves this fallback set. The fallback clears only at an edge whose interval did not saturate. Before saturation, acceleration mode produces no fixed-period mclk.
- R9: mclk is high for exactly one clock. An accepted FG edge cancels any pending delay and restarts it from the new interval.
- R10: Counters advance only on clocks where tick is high. With tick held low, no mclk is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable, one clock wide |
| fg | input | 1 | Zero-crossing feedback, asynchronous |
| mode | input | 2 | 00 start-up, 01 acceleration, 1x running |
| mclk | output | 1 | Commutation clock pulse |
| mask | output | 1 | Blanking window after each mclk |
| retry | output | 1 | Start-up polarity mismatch pulse |

## Verification
The bound checker watches several rules on every cycle. mclk is never high two clocks in a row, and no mclk follows a clock without a tick. The mask only rises together with mclk. retry is a single clock and appears only after start-up mode. The delay and mask lengths as fractions of the interval need the bench's scenarios, as do the start-up period, the glitch filter, polarity retry, blanking, cancellation of a pending delay and the saturation fallback. The bench checks these by driving FG trains with known spacing and timing the outputs.

// File: rtl/bldc_comm_clock.sv
module bldc_comm_clock #(
  parameter int CNT_W        = 20,
  parameter int QUAL_TICKS   = 4,
  parameter int START_PERIOD = 2000,
  parameter int START_MASK   = 1000,
  parameter int RUN_MASK     = 344
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fg,
  input  logic [1:0] mode,
  output logic       mclk,
  output logic       mask,
  output logic       retry
);

  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam logic [QW-1:0]    QUAL_LAST  = QW'(QUAL_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_PERIOD - 1);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic             fg_s1, fg_s2, fg_q, edge_p;
  logic [QW-1:0]    stab;
  logic [CNT_W-1:0] icnt, last, dcnt, scnt, mcnt;
  logic             slow, pend, exp_pol;

  logic             startup_t, run_m, sat, mism, fire_s, fire_d;
  logic [CNT_W-1:0] dly_val, mlen;

  assign run_m     = mode[1];
  assign startup_t = (mode == 2'b00) || slow;
  assign sat       = (icnt == CNT_MAX);
  assign mism      = edge_p && (mode == 2'b00) && (fg_q != exp_pol);
  assign dly_val   = run_m ? (icnt >> 5) : (icnt >> 1);
  assign mlen      = startup_t ? CNT_W'(START_MASK) :
                     run_m     ? CNT_W'(RUN_MASK)   : (last >> 2);
  assign fire_s    = startup_t && tick && !mism && (scnt == START_LAST);
  assign fire_d    = !startup_t && !edge_p && pend && tick && (dcnt <= ONE);
  assign mask      = (mcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fg_s1  <= 1'b0;
      fg_s2  <= 1'b0;
      fg_q   <= 1'b0;
      stab   <= '0;
      edge_p <= 1'b0;
    end else begin
      fg_s1  <= fg;
      fg_s2  <= fg_s1;
      edge_p <= 1'b0;
      if (mask) begin
        stab <= '0;
      end else if (tick) begin
        if (fg_s2 != fg_q) begin
          if (stab == QUAL_LAST) begin
            fg_q   <= fg_s2;
            stab   <= '0;
            edge_p <= 1'b1;
          end else begin
            stab <= stab + 1'b1;
          end
        end else begin
          stab <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt <= '0;
      last <= '0;
      slow <= 1'b1;
    end else if (edge_p) begin
      icnt <= '0;
      last <= icnt;
      slow <= sat;
    end else begin
      if (tick && !sat) icnt <= icnt + ONE;
      if (sat) slow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      pend <= 1'b0;
    end else if (startup_t) begin
      pend <= 1'b0;
    end else if (edge_p) begin
      dcnt <= dly_val;
      pend <= 1'b1;
    end else if (tick && pend) begin
      if (dcnt <= ONE) pend <= 1'b0;
      else             dcnt <= dcnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt    <= '0;
      exp_pol <= 1'b0;
    end else if (!startup_t || mism) begin
      scnt    <= '0;
      exp_pol <= 1'b0;
    end else if (tick) begin
      scnt <= (scnt == START_LAST) ? '0 : scnt + ONE;
      if (fire_s) exp_pol <= ~exp_pol;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt  <= '0;
      mclk  <= 1'b0;
      retry <= 1'b0;
    end else begin
      mclk  <= fire_s | fire_d;
      retry <= mism;
      if (mism)                 mcnt <= '0;
      else if (fire_s | fire_d) mcnt <= mlen;
      else if (tick && mask)    mcnt <= mcnt - ONE;
    end
  end

endmodule

// File: rtl/bldc_comm_clock_chk.sv
module bldc_comm_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [1:0] mode,
  input logic       mclk,
  input logic       mask,
  input logic       retry
);

  p_mclk_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mclk |=> !mclk);

  p_no_tick_no_mclk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !mclk);

  p_mask_opens_with_mclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask) |-> mclk);

  p_retry_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> !retry);

  p_retry_in_startup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> ($past(mode) == 2'b00));

endmodule

bind bldc_comm_clock bldc_comm_clock_chk chk_i (.*);

// File: tb/bldc_comm_clock_tb_top.sv
module bldc_comm_clock_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       fg = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       mclk, mask, retry;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bldc_comm_clock #(
    .CNT_W(12), .QUAL_TICKS(4), .START_PERIOD(40), .START_MASK(20), .RUN_MASK(7)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fg(fg), .mode(mode),
    .mclk(mclk), .mask(mask), .retry(retry)
  );

  // {mode, interval, expected delay, expected mask}
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{1,  200, 106,  49},
    '{1,  300, 156,  74},
    '{1,  520, 266, 129},
    '{1, 1000, 506, 249},
    '{2,  400,  19,   7},
    '{2,  640,  26,   7},
    '{3, 1024,  38,   7},
    '{2, 2000,  69,   7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_mclk(output int n, input int lim);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!mclk && n < lim);
  endtask

  task automatic count_mask(output int n);
    n = 0;
    while (mask && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic watch(input int cycles, output int nm, output int nr);
    nm = 0;
    nr = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (mclk) nm++;
      if (retry) nr++;
    end
  endtask

  task automatic train(input int p, input int edges);
    for (int e = 0; e < edges; e++) begin
      for (int c = 0; c < p - 1; c++) @(negedge clk);
      fg = ~fg;
      @(negedge clk);
    end
  endtask

  int n, m, nm, nr;
  bit w;

  initial begin
    // R1 reset state
    repeat (5) @(negedge clk);
    chk(!mclk && !mask && !retry, "R1 outputs low in reset", {mclk, mask, retry}, 0);
    rst_n = 1'b1;

    // R7 mismatch right after reset (expected polarity 0, edge to 1)
    fg = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!retry && n < 30);
    chk(retry == 1'b1, "R7 retry on polarity mismatch", retry, 1);
    wait_mclk(n, 200);
    chk(n >= 39 && n <= 41, "R7 start-up restart after retry", n, 40);

    // R3 period, R9 width, R3 mask
    wait_mclk(n, 200);
    chk(n == 40, "R3 start-up period", n, 40);
    @(negedge clk);
    chk(!mclk, "R9 mclk one clock wide", mclk, 0);
    count_mask(m);
    chk(m >= 18 && m <= 20, "R3 start-up mask length", m + 1, 20);

    // R7 matching edge: expected now 0, fg goes to 0
    fg = 1'b0;
    watch(20, nm, nr);
    chk(nr == 0, "R7 matching edge gives no retry", nr, 0);

    // R2 short glitch ignored
    wait_mclk(n, 200);
    while (mask) @(negedge clk);
    fg = 1'b1;
    repeat (3) @(negedge clk);
    fg = 1'b0;
    watch(20, nm, nr);
    chk(nr == 0, "R2 three-tick glitch rejected", nr, 0);

    // R6 pulse inside mask ignored
    wait_mclk(n, 200);
    fg = 1'b1;
    repeat (8) @(negedge clk);
    fg = 1'b0;
    watch(30, nm, nr);
    chk(nr == 0, "R6 pulse inside mask ignored", nr, 0);

    // R10 no tick, no clock
    tick = 1'b0;
    watch(150, nm, nr);
    chk(nm == 0, "R10 no mclk without tick", nm, 0);
    tick = 1'b1;

    // R4 / R5 table
    for (int v = 0; v < NV; v++) begin
      mode = 2'(VEC[v][0]);
      train(VEC[v][1], 5);
      wait_mclk(n, 3000);
      n = n + 1;
      chk(n >= VEC[v][2] - 3 && n <= VEC[v][2] + 3,
          (VEC[v][0] == 1) ? "R4 accel delay" : "R5 running delay", n, VEC[v][2]);
      count_mask(m);
      chk(m >= VEC[v][3] - 1 && m <= VEC[v][3] + 1,
          (VEC[v][0] == 1) ? "R4 accel mask" : "R5 running mask", m, VEC[v][3]);
    end

    // R9 cancel: second edge before the pending mclk
    mode = 2'b01;
    train(400, 5);
    watch(99, nm, nr);
    chk(nm == 0, "R9 no mclk before cancelling edge", nm, 0);
    fg = ~fg;
    wait_mclk(n, 1000);
    chk(n >= 53 && n <= 59, "R9 delay restarted from new interval", n, 56);
    watch(300, nm, nr);
    chk(nm == 0, "R9 old delay cancelled", nm, 0);

    // R8 saturation fallback
    watch(3500, nm, nr);
    chk(nm == 0, "R8 no fixed clock before saturation", nm, 0);
    wait_mclk(n, 1000);
    chk(mclk == 1'b1, "R8 clock resumes after saturation", mclk, 1);
    wait_mclk(n, 200);
    chk(n == 40, "R8 start-up period after saturation", n, 40);

    w = 1'b1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

endmodule